// File: doc/BRIEF.md
# SPI Memory-Mapped Transaction Engine

This block is an SPI master that drives memory reads, memory writes and short host commands into a graphics controller with a 22-bit address space. A host asks for one operation per `start` pulse: it gives an operation code, an address, a byte count and either a stream of write bytes or a 32-bit word. The engine frames the whole operation under one chip select and returns read bytes one at a time with a strobe.

Every memory access opens with three address bytes, most significant first. The top bit of the first byte marks a write. A read clocks one throw-away byte before the data arrives. In word mode the engine moves a 16-bit or 32-bit value least-significant byte first, on both the write and the read side. A fixed divider parameter sets the serial clock rate. Between two frames the chip select stays high for a minimum time.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0 and `busy` is 0. `sck` is low on every cycle in which `cs_n` is high.
- R2: Serial mode 0 with 8-bit frames. Each byte gives 8 `sck` pulses, MSB first. `mosi` is sampled by the target on the rising edge, and `miso` is captured on the rising edge. Each `sck` high phase and each low phase lasts CLK_DIV clocks.
- R3: Operation codes are 2'b00 command, 2'b01 read and 2'b10 write. A read or write sends three address bytes first: {W, 0, addr[21:16]}, then addr[15:8], then addr[7:0]. W is 1 for a write and 0 for a read.
- R4: A read sends one 0x00 dummy byte after the address, then `count` data bytes, with `mosi` at 0x00 throughout. Each byte captured on `miso` appears on `rdata` with a one-cycle `rdata_valid` pulse, in arrival order.
- R5: A burst write (word_mode=0) sends `count` data bytes taken from `wdata`. Each byte is sampled on the clock edge before the cycle in which `wdata_take` pulses. The host then presents the next byte.
- R6: In word mode a write sends the low `count` bytes (1 to 4) of `wword`, least-significant byte first, and `wdata_take` stays low. A read in word mode places data byte i in `rword[8i+7:8i]`, and this is valid when `op_done` pulses.
- R7: A command (op 2'b00) sends exactly three bytes: `cmd`, 0x00, 0x00. `addr` and `count` are ignored.
- R8: `cs_n` stays low from the first byte to the last byte of an operation and rises once after the last byte. `op_done` pulses in the cycle in which `cs_n` goes high.
- R9: Between frames `cs_n` stays high for at least two `sck` periods (4*CLK_DIV clocks). `busy` stays high until that gap has elapsed.
- R10: A `start` while `busy` is high is ignored. A `start` with op 2'b11 starts no frame and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one operation |
| op | input | 2 | Operation code (see R3) |
| word_mode | input | 1 | Use `wword`/`rword` instead of the byte stream |
| addr | input | ADDR_W | Target address |
| count | input | CNT_W | Number of data bytes |
| cmd | input | 8 | Command byte for op 2'b00 |
| wdata | input | 8 | Burst write byte |
| wword | input | 32 | Word-mode write value |
| wdata_take | output | 1 | Burst write byte has been consumed |
| rdata | output | 8 | Read byte |
| rdata_valid | output | 1 | `rdata` holds a new byte |
| rword | output | 32 | Word-mode read value |
| busy | output | 1 | Operation or closing gap in progress |
| op_done | output | 1 | Frame has just closed |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two events can land on the same clock edge. A host `start` can arrive while the engine is still in a frame or in its closing gap. The last read byte's capture also happens on the same edge that raises chip select. The first case is provoked by pulsing `start` with a command code in the middle of a read. The check is that only one frame appears, with the read's byte count and header. The second case is judged by counting the `rdata_valid` pulses and matching their values against the bytes that the target model placed on `miso`. This includes the final byte of each read.

// File: rtl/spi_xact_pkg.sv
// Shared types for the SPI transaction engine.
package spi_xact_pkg;
    typedef enum logic [1:0] {
        OP_CMD   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_XFER,
        PH_GAP
    } phase_e;
endpackage

// File: rtl/spi_xact_shifter.sv
// Byte shifter, serial mode 0. It sends tx MSB first and captures miso on
// each rising sck edge. Each half period of sck is CLK_DIV clocks.
// Assumes go is only pulsed while the shifter is idle.
module spi_xact_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_n;
    logic [7:0]    sreg;
    logic          active;

    assign mosi = sreg[7];

    // Purpose: step through the eight bit cells of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_n   <= '0;
            sreg    <= '0;
            rx      <= '0;
            sck     <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                sreg    <= tx;
                bit_n   <= '0;
                div_cnt <= '0;
                sck     <= 1'b0;
            end else if (active) begin
                if (div_cnt == DW'(CLK_DIV - 1)) begin
                    div_cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_n == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            sreg  <= {sreg[6:0], 1'b0};
                            bit_n <= bit_n + 3'd1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_xact_wordbuf.sv
// Word buffer for word-mode operations. It latches the write word at the
// start of an operation and selects its bytes by index. It also assembles
// captured read bytes into one word. Assumes an index below NBYTES.
module spi_xact_wordbuf #(
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [8*NBYTES-1:0]   word_in,
    input  logic [1:0]            sel,
    output logic [7:0]            byte_out,
    input  logic                  cap,
    input  logic [1:0]            cap_idx,
    input  logic [7:0]            cap_byte,
    output logic [8*NBYTES-1:0]   word_out
);
    logic [7:0] wlane [NBYTES];

    assign byte_out = wlane[sel];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [7:0] rlane;

        // Purpose: hold one write byte lane and one read byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wlane[g] <= '0;
                rlane    <= '0;
            end else if (load) begin
                wlane[g] <= word_in[8*g +: 8];
                rlane    <= '0;
            end else if (cap && (cap_idx == 2'(g))) begin
                rlane    <= cap_byte;
            end
        end

        assign word_out[8*g +: 8] = rlane;
    end
endmodule

// File: rtl/spi_xact_seq.sv
// Frame sequencer. It accepts one operation from IDLE and lowers cs_n. It
// feeds the shifter header, dummy and data bytes in order, then raises
// cs_n and holds a minimum gap. Assumes count fits the burst in CNT_W bits.
module spi_xact_seq
    import spi_xact_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int CNT_W   = 16,
    parameter int CLK_DIV = 2,
    parameter int GAP_SCK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [7:0]        cmd,
    input  logic [7:0]        wdata,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    input  logic [7:0]        wb_byte,
    output logic              sh_go,
    output logic [7:0]        sh_tx,
    output logic              wb_load,
    output logic [1:0]        wb_sel,
    output logic              wb_cap,
    output logic [1:0]        wb_cap_idx,
    output logic              wdata_take,
    output logic [7:0]        rdata,
    output logic              rdata_valid,
    output logic              busy,
    output logic              op_done,
    output logic              cs_n
);
    localparam int POS_W    = CNT_W + 2;
    localparam int GAP_CLKS = GAP_SCK * 2 * CLK_DIV;
    localparam int GW       = $clog2(GAP_CLKS + 1);

    phase_e          phase;
    op_e             op_q;
    logic            wmode_q;
    logic [15:0]     addr_lo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos;
    logic [GW-1:0]   gap_cnt;

    logic [23:0]     addr_ext;
    logic            accept;
    logic [7:0]      first_tx;
    logic [POS_W-1:0] nxt_pos, hdr_len, total;
    logic [1:0]      didx, ridx;
    logic            in_rdata, wr_data_next;
    logic [7:0]      nxt_tx;

    // Purpose: form the first byte of a frame from the request inputs.
    always_comb begin
        addr_ext = 24'(addr);
        accept   = start && (phase == PH_IDLE) && (op_e'(op) != OP_NONE);
        if (op_e'(op) == OP_CMD)
            first_tx = cmd;
        else
            first_tx = addr_ext[23:16] | ((op_e'(op) == OP_WRITE) ? 8'h80 : 8'h00);
    end

    // Purpose: compute the next byte to send and where the current read byte belongs.
    always_comb begin
        nxt_pos      = pos + POS_W'(1);
        hdr_len      = (op_q == OP_READ) ? POS_W'(4) : POS_W'(3);
        total        = (op_q == OP_CMD) ? POS_W'(3) : hdr_len + POS_W'(cnt_q);
        didx         = nxt_pos[1:0] - hdr_len[1:0];
        ridx         = pos[1:0] - hdr_len[1:0];
        in_rdata     = (op_q == OP_READ) && (pos >= hdr_len);
        wr_data_next = (op_q == OP_WRITE) && (nxt_pos >= POS_W'(3));
        nxt_tx       = 8'h00;
        if (op_q != OP_CMD) begin
            if (nxt_pos == POS_W'(1))
                nxt_tx = addr_lo_q[15:8];
            else if (nxt_pos == POS_W'(2))
                nxt_tx = addr_lo_q[7:0];
            else if (wr_data_next)
                nxt_tx = wmode_q ? wb_byte : wdata;
        end
    end

    assign wb_load    = accept;
    assign wb_sel     = didx;
    assign wb_cap     = sh_done && in_rdata && wmode_q && (phase == PH_XFER);
    assign wb_cap_idx = ridx;

    // Purpose: run the idle / transfer / gap phases of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            op_q        <= OP_CMD;
            wmode_q     <= 1'b0;
            addr_lo_q   <= '0;
            cnt_q       <= '0;
            pos         <= '0;
            gap_cnt     <= '0;
            sh_go       <= 1'b0;
            sh_tx       <= '0;
            wdata_take  <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
            busy        <= 1'b0;
            op_done     <= 1'b0;
            cs_n        <= 1'b1;
        end else begin
            sh_go       <= 1'b0;
            wdata_take  <= 1'b0;
            rdata_valid <= 1'b0;
            op_done     <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        op_q      <= op_e'(op);
                        wmode_q   <= word_mode;
                        addr_lo_q <= addr_ext[15:0];
                        cnt_q     <= count;
                        pos       <= '0;
                        busy      <= 1'b1;
                        cs_n      <= 1'b0;
                        sh_go     <= 1'b1;
                        sh_tx     <= first_tx;
                        phase     <= PH_XFER;
                    end
                end
                PH_XFER: begin
                    if (sh_done) begin
                        if (in_rdata) begin
                            rdata       <= sh_rx;
                            rdata_valid <= 1'b1;
                        end
                        if (nxt_pos == total) begin
                            cs_n    <= 1'b1;
                            op_done <= 1'b1;
                            gap_cnt <= '0;
                            phase   <= PH_GAP;
                        end else begin
                            pos        <= nxt_pos;
                            sh_go      <= 1'b1;
                            sh_tx      <= nxt_tx;
                            wdata_take <= wr_data_next && !wmode_q;
                        end
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == GW'(GAP_CLKS - 1)) begin
                        busy  <= 1'b0;
                        phase <= PH_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_xact_engine.sv
// Top of the SPI memory-mapped transaction engine. It connects the frame
// sequencer, the byte shifter and the word buffer. Assumes ADDR_W <= 22.
module spi_xact_engine #(
    parameter int ADDR_W  = 22,
    parameter int CNT_W   = 16,
    parameter int CLK_DIV = 2,
    parameter int GAP_SCK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [7:0]        cmd,
    input  logic [7:0]        wdata,
    input  logic [31:0]       wword,
    output logic              wdata_take,
    output logic [7:0]        rdata,
    output logic              rdata_valid,
    output logic [31:0]       rword,
    output logic              busy,
    output logic              op_done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int WORD_BYTES = 4;

    logic       sh_go, sh_done;
    logic [7:0] sh_tx, sh_rx;
    logic       wb_load, wb_cap;
    logic [1:0] wb_sel, wb_cap_idx;
    logic [7:0] wb_byte;

    spi_xact_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word_mode(word_mode),
        .addr(addr), .count(count), .cmd(cmd), .wdata(wdata),
        .sh_done(sh_done), .sh_rx(sh_rx), .wb_byte(wb_byte),
        .sh_go(sh_go), .sh_tx(sh_tx), .wb_load(wb_load), .wb_sel(wb_sel),
        .wb_cap(wb_cap), .wb_cap_idx(wb_cap_idx), .wdata_take(wdata_take),
        .rdata(rdata), .rdata_valid(rdata_valid), .busy(busy),
        .op_done(op_done), .cs_n(cs_n)
    );

    spi_xact_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .done(sh_done), .rx(sh_rx)
    );

    spi_xact_wordbuf #(.NBYTES(WORD_BYTES)) u_word (
        .clk(clk), .rst_n(rst_n), .load(wb_load), .word_in(wword),
        .sel(wb_sel), .byte_out(wb_byte), .cap(wb_cap), .cap_idx(wb_cap_idx),
        .cap_byte(sh_rx), .word_out(rword)
    );
endmodule

// File: rtl/spi_xact_checker.sv
// Protocol checker for spi_xact_engine. It is attached to every instance
// by the bind below and only observes the ports.
module spi_xact_checker #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic busy,
    input logic wdata_take,
    input logic rdata_valid,
    input logic op_done
);
    localparam int MIN_HI = 4 * CLK_DIV;

    logic [15:0] hi_cnt;

    // Purpose: count the cycles cs_n has been high, saturating at MIN_HI.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= 16'(MIN_HI);
        else if (!cs_n)
            hi_cnt <= '0;
        else if (hi_cnt < 16'(MIN_HI))
            hi_cnt <= hi_cnt + 16'd1;
    end

    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    a_r2_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> !cs_n);
    a_r5_take_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_take |-> (busy && !cs_n));
    a_r8_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (cs_n && $rose(cs_n)));
    a_r4_rdata_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> busy);
    a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 16'(MIN_HI)));
    a_r9_busy_over_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> busy);
endmodule

bind spi_xact_engine spi_xact_checker #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .busy(busy),
    .wdata_take(wdata_take), .rdata_valid(rdata_valid), .op_done(op_done)
);

// File: tb/spi_xact_engine_test.sv
// Directed bench for spi_xact_engine with a mode-0 target model.
module spi_xact_engine_test;
    localparam int DIV = 2;
    localparam int GSCK = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        word_mode = 1'b0;
    logic [21:0] addr = '0;
    logic [15:0] count = '0;
    logic [7:0]  cmd = '0;
    logic [7:0]  wdata;
    logic [31:0] wword = '0;
    logic        wdata_take, rdata_valid, busy, op_done, sck, mosi, cs_n;
    logic        miso = 1'b0;
    logic [7:0]  rdata;
    logic [31:0] rword;

    spi_xact_engine #(.ADDR_W(22), .CNT_W(16), .CLK_DIV(DIV), .GAP_SCK(GSCK)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word_mode(word_mode),
        .addr(addr), .count(count), .cmd(cmd), .wdata(wdata), .wword(wword),
        .wdata_take(wdata_take), .rdata(rdata), .rdata_valid(rdata_valid),
        .rword(rword), .busy(busy), .op_done(op_done), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_fail = 0;
    logic wd_hit = 1'b0;

    // write-data source, indexed by the monitor only
    logic [7:0] wbuf [64];
    logic [5:0] widx = '0;
    assign wdata = wbuf[widx];

    // monitor / target state
    logic       prev_sck = 1'b0, prev_cs = 1'b1;
    logic [7:0] m_sh = '0, sl_out = '0;
    int         m_bit = 0, sl_k = 0;
    logic [7:0] mo_log [1024];
    int         mo_n = 0;
    logic [7:0] rd_log [256];
    int         rd_n = 0, tk_n = 0, fr_n = 0;
    int         hi_run = 0, last_gap = 0, sck_hi_run = 0, last_sck_hi = 0;
    int         partial_bad = 0, idle_bad = 0;

    function automatic logic [7:0] pat(input int k);
        return 8'h35 + 8'(k) * 8'h1D;
    endfunction

    // target model and port monitor, sampling away from the clock edge
    always @(negedge clk) begin
        if (!cs_n && prev_cs) begin
            sl_k = 0;
            sl_out = pat(0);
            miso = sl_out[7];
            m_bit = 0;
            last_gap = hi_run;
        end
        if (cs_n && !prev_cs) begin
            fr_n++;
            if (m_bit != 0) partial_bad++;
        end
        hi_run = cs_n ? hi_run + 1 : 0;
        if (!cs_n && sck && !prev_sck) begin
            m_sh = {m_sh[6:0], mosi};
            m_bit++;
            if (m_bit == 8) begin
                mo_log[mo_n % 1024] = m_sh;
                mo_n++;
                m_bit = 0;
            end
        end
        if (!cs_n && !sck && prev_sck) begin
            if (m_bit == 0) begin
                sl_k++;
                sl_out = pat(sl_k);
            end else begin
                sl_out = {sl_out[6:0], 1'b0};
            end
            miso = sl_out[7];
        end
        if (sck) sck_hi_run++;
        else if (prev_sck) begin
            last_sck_hi = sck_hi_run;
            sck_hi_run = 0;
        end
        if (cs_n && sck) idle_bad++;
        if (rdata_valid) begin
            rd_log[rd_n % 256] = rdata;
            rd_n++;
        end
        if (wdata_take) begin
            widx = widx + 6'd1;
            tk_n++;
        end
        prev_sck = sck;
        prev_cs = cs_n;
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            wd_hit = 1'b1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] o, input logic wm, input logic [21:0] a,
                         input logic [15:0] c, input logic [7:0] cb, input logic [31:0] ww);
        op = o; word_mode = wm; addr = a; count = c; cmd = cb; wword = ww;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && !wd_hit) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 cs_n after reset", 32'(cs_n), 32'd1);
        chk("R1 sck after reset", 32'(sck), 32'd0);
        chk("R1 busy after reset", 32'(busy), 32'd0);
    endtask

    task automatic t_command;
        int b = mo_n, f = fr_n;
        do_op(2'b00, 1'b0, 22'h3FFFFF, 16'd9, 8'h61, 32'h0);
        chk("R8 one frame for command", 32'(fr_n - f), 32'd1);
        chk("R7 command length", 32'(mo_n - b), 32'd3);
        chk("R7 command byte", 32'(mo_log[b]), 32'h61);
        chk("R7 command pad 1", 32'(mo_log[b+1]), 32'h00);
        chk("R7 command pad 2", 32'(mo_log[b+2]), 32'h00);
        chk("R2 sck high phase", 32'(last_sck_hi), 32'(DIV));
    endtask

    task automatic t_write_burst;
        int b = mo_n, t = tk_n;
        logic [7:0] d [5] = '{8'hC1, 8'h02, 8'hE3, 8'h74, 8'h95};
        for (int i = 0; i < 5; i++) wbuf[6'(widx + 6'(i))] = d[i];
        do_op(2'b10, 1'b0, 22'h3F0ABC, 16'd5, 8'h00, 32'h0);
        chk("R3 write length", 32'(mo_n - b), 32'd8);
        chk("R3 write addr hi with W", 32'(mo_log[b]), 32'hBF);
        chk("R3 write addr mid", 32'(mo_log[b+1]), 32'h0A);
        chk("R3 write addr lo", 32'(mo_log[b+2]), 32'hBC);
        for (int i = 0; i < 5; i++) chk("R5 burst data byte", 32'(mo_log[b+3+i]), 32'(d[i]));
        chk("R5 take pulses", 32'(tk_n - t), 32'd5);
    endtask

    task automatic t_write_words;
        int b = mo_n, t = tk_n;
        do_op(2'b10, 1'b1, 22'h000100, 16'd4, 8'h00, 32'h11223344);
        chk("R6 word32 length", 32'(mo_n - b), 32'd7);
        chk("R6 word32 bytes", {mo_log[b+6], mo_log[b+5], mo_log[b+4], mo_log[b+3]}, 32'h11223344);
        chk("R6 no take in word mode", 32'(tk_n - t), 32'd0);
        b = mo_n;
        do_op(2'b10, 1'b1, 22'h000200, 16'd2, 8'h00, 32'hCAFEBEEF);
        chk("R6 word16 length", 32'(mo_n - b), 32'd5);
        chk("R6 word16 bytes", 32'({mo_log[b+4], mo_log[b+3]}), 32'hBEEF);
    endtask

    task automatic t_read_burst;
        int b = mo_n, r = rd_n;
        do_op(2'b01, 1'b0, 22'h012345, 16'd3, 8'h00, 32'h0);
        chk("R4 read length", 32'(mo_n - b), 32'd7);
        chk("R3 read addr hi no W", 32'(mo_log[b]), 32'h01);
        chk("R3 read addr mid", 32'(mo_log[b+1]), 32'h23);
        chk("R3 read addr lo", 32'(mo_log[b+2]), 32'h45);
        for (int i = 3; i < 7; i++) chk("R4 mosi zero in read", 32'(mo_log[b+i]), 32'h00);
        chk("R4 rdata count", 32'(rd_n - r), 32'd3);
        for (int i = 0; i < 3; i++) chk("R4 rdata value", 32'(rd_log[r+i]), 32'(pat(4+i)));
    endtask

    task automatic t_read_word;
        do_op(2'b01, 1'b1, 22'h000400, 16'd4, 8'h00, 32'h0);
        chk("R6 rword assembly", rword, {pat(7), pat(6), pat(5), pat(4)});
    endtask

    task automatic t_gap;
        do_op(2'b00, 1'b0, 22'h0, 16'd0, 8'h44, 32'h0);
        do_op(2'b00, 1'b0, 22'h0, 16'd0, 8'h45, 32'h0);
        chk("R9 cs_n gap at least two sck periods", 32'(last_gap >= 4 * DIV), 32'd1);
        chk("R8 no partial byte in any frame", 32'(partial_bad), 32'd0);
        chk("R1 sck low while cs_n high", 32'(idle_bad), 32'd0);
    endtask

    task automatic t_illegal;
        int f = fr_n;
        do_op(2'b11, 1'b0, 22'h0, 16'd3, 8'h00, 32'h0);
        repeat (4) @(negedge clk);
        chk("R10 op 11 no frame", 32'(fr_n - f), 32'd0);
        chk("R10 op 11 not busy", 32'(busy), 32'd0);
    endtask

    task automatic t_busy_start;
        int b = mo_n, f = fr_n, r = rd_n;
        op = 2'b01; word_mode = 1'b0; addr = 22'h2A5501; count = 16'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        op = 2'b00; cmd = 8'h68;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && !wd_hit) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 start while busy ignored frames", 32'(fr_n - f), 32'd1);
        chk("R10 start while busy ignored length", 32'(mo_n - b), 32'd6);
        chk("R10 header kept", 32'(mo_log[b]), 32'h2A);
        chk("R4 last read byte at close", 32'(rd_log[r+1]), 32'(pat(5)));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_command();
        t_write_burst();
        t_write_words();
        t_read_burst();
        t_read_word();
        t_gap();
        t_illegal();
        t_busy_start();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule